// File: doc/BRIEF.md
# Orbit Interval Capture Monitor

This block measures orbit health by counting how many bunch-clock cycles separate one orbit pulse from the next. A free-running 16-bit gap counter restarts on every orbit pulse. When software issues an arm command, the block clears its buffer and waits for the next orbit pulse. That pulse closes an interval that began before the arm, so it is thrown away. The block then stores the following 128 intervals and stops by itself.

Software drains the buffer one entry per read strobe, oldest entry first. A healthy machine gives the nominal 3564 cycles in every entry. Entries that scatter, shrink or saturate point to a wrong comparator threshold, a phase problem or a loss of synchronisation. Reads may overlap an ongoing capture. Status outputs report the fill level, empty, full, a capture in progress, capture done, and a sticky flag for reads from an empty buffer.

Top module: `orbit_gap_monitor`

## Requirements
- R1: A stored entry equals the number of clock cycles from one orbit pulse to the next. Pulses on adjacent cycles give 1, and pulses 3564 cycles apart give 3564.
- R2: When an interval exceeds 65535 cycles, the stored entry is 65535.
- R3: Before the first arm command, orbit pulses store nothing: level_o stays 0 and busy_o stays 0.
- R4: After an arm command, the first orbit pulse stores nothing. Each later pulse stores one entry.
- R5: Capture stops after 128 stored entries. At that point done_o=1, busy_o=0 and full_o=1, and further orbit pulses leave level_o unchanged.
- R6: Each read strobe loads the oldest stored entry onto rd_data_o on the clock edge that samples the strobe, and removes that entry. Entries come out in the order they were stored.
- R7: A read strobe while level_o is 0 puts 0 on rd_data_o and sets underflow_o. underflow_o then stays 1 until the next arm command or reset.
- R8: An arm command empties the buffer, clears underflow_o and done_o, zeroes rd_data_o and raises busy_o. An orbit pulse in the same cycle as the arm is ignored, and the pulse after it is treated as the discarded first pulse.
- R9: After reset the outputs read level_o=0, empty_o=1, full_o=0, busy_o=0, done_o=0, underflow_o=0 and rd_data_o=0.
- R10: A read strobe and a storing orbit pulse in the same cycle both take effect. The read returns the older entry, and level_o is unchanged.
- R11: empty_o is 1 exactly when level_o is 0, and full_o is 1 exactly when level_o is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_i | input | 1 | One-cycle arm command; clears and restarts capture |
| orbit_i | input | 1 | One-cycle orbit pulse, synchronous to clk |
| rd_i | input | 1 | One-cycle read strobe |
| rd_data_o | output | 16 | Entry returned by the last read strobe |
| level_o | output | 8 | Number of stored, unread entries |
| empty_o | output | 1 | Buffer holds no entries |
| full_o | output | 1 | Buffer holds 128 entries |
| busy_o | output | 1 | Armed and not yet done |
| done_o | output | 1 | 128 entries have been captured since the last arm |
| underflow_o | output | 1 | Sticky: a read hit an empty buffer |

## Verification
The bench first targets the discarded pulse after arming. A design that stores the partial interval shows one extra, wrong entry at the head of the buffer. It also races an arm against an orbit pulse in the same cycle. If the arm does not win that race, the design stores one interval too many. An interval of 70000 cycles checks saturation: a counter that wraps instead of saturating stores 4464. The bench fills the buffer past 128 pulses, checks that capture stops at exactly 128 entries, and checks that those entries come out in the order stored. It also overlaps a read with a write, where a broken level update drifts by one, and reads an empty buffer, where a non-sticky or uncleared underflow flag shows up.

// File: rtl/ogm_pkg.sv
package ogm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } ogm_state_e;
endpackage

// File: rtl/ogm_rst_sync.sv
module ogm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ogm_gap_counter.sv
module ogm_gap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit_i,
  output logic [CNT_W-1:0] gap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = orbit_i || (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (orbit_i)     cnt_d = CNT_ONE;
    else if (cnt_en) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign gap_o = cnt_q;

  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !orbit_i) |=> (gap_o == CNT_MAX));

  // R1
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    orbit_i |=> (gap_o == CNT_ONE));
endmodule

// File: rtl/ogm_ctrl.sv
module ogm_ctrl
  import ogm_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic orbit_i,
  output logic clear_o,
  output logic wr_en_o,
  output logic busy_o,
  output logic done_o
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(DEPTH - 1);

  ogm_state_e       state_q, state_d;
  logic [LVL_W-1:0] wcnt_q, wcnt_d;
  logic             wr_en;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    wr_en   = 1'b0;
    if (arm_i) begin
      state_d = ST_SYNC;
      wcnt_d  = '0;
    end else begin
      case (state_q)
        ST_SYNC: if (orbit_i) state_d = ST_CAPT;
        ST_CAPT: begin
          if (orbit_i) begin
            wr_en  = 1'b1;
            wcnt_d = wcnt_q + LVL_W'(1);
            if (wcnt_q == LAST) state_d = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign clear_o = arm_i;
  assign wr_en_o = wr_en;
  assign busy_o  = (state_q == ST_SYNC) || (state_q == ST_CAPT);
  assign done_o  = (state_q == ST_DONE);

  // R5
  wcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= LVL_W'(DEPTH));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> done_o);

  // R8
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (busy_o && !done_o && wcnt_q == '0));

  // R4
  skip_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC) |-> !wr_en_o);
endmodule

// File: rtl/ogm_store.sv
module ogm_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 7,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              underflow_o
);
  localparam logic [ADDR_W-1:0] PTR_LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;
  logic              uflow_q, uflow_d;
  logic              rd_ok, wr_ok;

  function automatic logic [ADDR_W-1:0] ptr_inc(input logic [ADDR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + ADDR_W'(1);
  endfunction

  assign wr_ok = wr_en_i && !clear_i;
  assign rd_ok = rd_i && !clear_i && (level_q != '0);

  always_comb begin
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    level_d   = level_q;
    rd_data_d = rd_data_q;
    uflow_d   = uflow_q;
    if (clear_i) begin
      wr_ptr_d  = '0;
      rd_ptr_d  = '0;
      level_d   = '0;
      rd_data_d = '0;
      uflow_d   = 1'b0;
    end else begin
      if (wr_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (rd_i) begin
        if (rd_ok) begin
          rd_data_d = mem_q[rd_ptr_q];
          rd_ptr_d  = ptr_inc(rd_ptr_q);
        end else begin
          rd_data_d = '0;
          uflow_d   = 1'b1;
        end
      end
      case ({wr_ok, rd_ok})
        2'b10:   level_d = level_q + LVL_W'(1);
        2'b01:   level_d = level_q - LVL_W'(1);
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      level_q   <= '0;
      rd_data_q <= '0;
      uflow_q   <= 1'b0;
    end else begin
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
      level_q   <= level_d;
      rd_data_q <= rd_data_d;
      uflow_q   <= uflow_d;
    end
  end

  assign rd_data_o   = rd_data_q;
  assign level_o     = level_q;
  assign underflow_o = uflow_q;

  // R7
  uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !clear_i) |=> underflow_o);

  // R7
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && level_o == '0 && !clear_i) |=> (rd_data_o == '0 && underflow_o));

  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LVL_W'(DEPTH));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (level_o == '0 && !underflow_o && rd_data_o == '0));

  // R10
  rw_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && rd_i && level_o != '0 && !clear_i) |=> $stable(level_o));
endmodule

// File: rtl/orbit_gap_monitor.sv
module orbit_gap_monitor #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm_i,
  input  logic                       orbit_i,
  input  logic                       rd_i,
  output logic [CNT_W-1:0]           rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       underflow_o
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic             rst_n_s;
  logic [CNT_W-1:0] gap;
  logic             clear, wr_en;
  logic [LVL_W-1:0] level;

  ogm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  ogm_gap_counter #(.CNT_W(CNT_W)) i_gap_counter (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .orbit_i (orbit_i),
    .gap_o   (gap)
  );

  ogm_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .arm_i   (arm_i),
    .orbit_i (orbit_i),
    .clear_o (clear),
    .wr_en_o (wr_en),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  ogm_store #(
    .DATA_W (CNT_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .LVL_W  (LVL_W)
  ) i_store (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .clear_i     (clear),
    .wr_en_i     (wr_en),
    .wr_data_i   (gap),
    .rd_i        (rd_i),
    .rd_data_o   (rd_data_o),
    .level_o     (level),
    .underflow_o (underflow_o)
  );

  assign level_o = level;
  assign empty_o = (level == '0);
  assign full_o  = (level == LVL_W'(DEPTH));

  // R5
  no_store_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && !rd_i && !arm_i) |=> $stable(level_o));

  // R3
  idle_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy_o && !done_o && !arm_i && !rd_i) |=> $stable(level_o));
endmodule

// File: tb/test_orbit_gap_monitor.sv
module test_orbit_gap_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm_i, orbit_i, rd_i;
  logic [15:0] rd_data_o;
  logic [7:0]  level_o;
  logic        empty_o, full_o, busy_o, done_o, underflow_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  orbit_gap_monitor i_orbit_gap_monitor (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .orbit_i(orbit_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .level_o(level_o), .empty_o(empty_o),
    .full_o(full_o), .busy_o(busy_o), .done_o(done_o),
    .underflow_o(underflow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm();
    arm_i = 1'b1; @(negedge clk); arm_i = 1'b0;
  endtask

  // one orbit pulse, then idle so the next pulse comes gap cycles later
  task automatic orbit_gap(input int gap);
    orbit_i = 1'b1; @(negedge clk); orbit_i = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic read_one(output int val);
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    val = int'(rd_data_o);
  endtask

  function automatic int fill_gap(input int i);
    return 10 + (i * 7) % 13;
  endfunction

  task automatic t_reset();
    chk("R9 level", int'(level_o), 0);
    chk("R9 empty", int'(empty_o), 1);
    chk("R9 full", int'(full_o), 0);
    chk("R9 busy", int'(busy_o), 0);
    chk("R9 done", int'(done_o), 0);
    chk("R9 underflow", int'(underflow_o), 0);
    chk("R9 rd_data", int'(rd_data_o), 0);
  endtask

  task automatic t_no_arm();
    for (int i = 0; i < 5; i++) orbit_gap(12);
    chk("R3 level before arm", int'(level_o), 0);
    chk("R3 busy before arm", int'(busy_o), 0);
  endtask

  task automatic t_basic();
    int v;
    int exp_q[4] = '{20, 20, 3564, 1};
    arm();
    chk("R8 busy after arm", int'(busy_o), 1);
    orbit_gap(20); // discarded
    chk("R4 first pulse discarded", int'(level_o), 0);
    orbit_gap(20);
    orbit_gap(3564);
    orbit_gap(1);
    orbit_gap(2);
    chk("R4 level after five pulses", int'(level_o), 4);
    chk("R11 not empty", int'(empty_o), 0);
    for (int i = 0; i < 4; i++) begin
      read_one(v);
      chk("R1 R6 entry value", v, exp_q[i]);
    end
    chk("R11 empty after drain", int'(empty_o), 1);
    read_one(v);
    chk("R7 empty read value", v, 0);
    chk("R7 underflow set", int'(underflow_o), 1);
    repeat (3) @(negedge clk);
    chk("R7 underflow sticky", int'(underflow_o), 1);
  endtask

  task automatic t_sat();
    int v;
    arm();
    chk("R8 underflow cleared by arm", int'(underflow_o), 0);
    orbit_gap(70000);
    orbit_gap(5);
    orbit_gap(3);
    chk("R2 level", int'(level_o), 2);
    read_one(v);
    chk("R2 saturated entry", v, 65535);
    read_one(v);
    chk("R1 entry after saturation", v, 5);
  endtask

  task automatic t_fill();
    int v;
    arm();
    for (int i = 0; i < 133; i++) orbit_gap(fill_gap(i));
    chk("R5 level", int'(level_o), 128);
    chk("R5 done", int'(done_o), 1);
    chk("R5 busy", int'(busy_o), 0);
    chk("R11 full", int'(full_o), 1);
    for (int i = 0; i < 128; i++) begin
      read_one(v);
      chk("R6 fill order", v, fill_gap(i));
    end
    chk("R11 empty after full drain", int'(empty_o), 1);
    chk("R11 full cleared", int'(full_o), 0);
    orbit_gap(9);
    chk("R5 no store after done", int'(level_o), 0);
  endtask

  task automatic t_concurrent();
    int v;
    arm();
    chk("R8 done cleared by arm", int'(done_o), 0);
    orbit_gap(11); // discarded
    orbit_gap(13); // stores 11
    chk("R10 level before overlap", int'(level_o), 1);
    orbit_i = 1'b1; rd_i = 1'b1;
    @(negedge clk);
    orbit_i = 1'b0; rd_i = 1'b0;
    v = int'(rd_data_o);
    chk("R10 overlap read value", v, 11);
    chk("R10 overlap level", int'(level_o), 1);
    read_one(v);
    chk("R10 written entry", v, 13);
  endtask

  task automatic t_arm_race();
    int v;
    arm();
    read_one(v);
    chk("R7 underflow before race", int'(underflow_o), 1);
    orbit_gap(8);
    orbit_gap(8);
    orbit_gap(8);
    chk("R8 level before race", int'(level_o), 2);
    arm_i = 1'b1; orbit_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0; orbit_i = 1'b0;
    chk("R8 cleared level", int'(level_o), 0);
    chk("R8 cleared underflow", int'(underflow_o), 0);
    chk("R8 rd_data zeroed", int'(rd_data_o), 0);
    repeat (9) @(negedge clk);
    orbit_gap(10); // discarded
    orbit_gap(10); // stores 10
    chk("R8 race pulse ignored", int'(level_o), 1);
    read_one(v);
    chk("R8 entry after race", v, 10);
  endtask

  initial begin
    arm_i = 1'b0; orbit_i = 1'b0; rd_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_arm();
    t_basic();
    t_sat();
    t_fill();
    t_concurrent();
    t_arm_race();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule